// File: doc/BRIEF.md
# Interrupt Trigger Notification Generator

This block sits at the level-sensitive interrupt edge of a bridge. It records the state of a fixed set of interrupt sources in a 64-bit level register, and it turns notification requests into single 64-bit memory stores. Each store carries a trigger word made from a fixed trigger flag, a table offset taken from the upper half of a programmable register, and the number of the requesting source. The store goes to a programmable notification address.

Software programs the block through a small write/read register port. It can set the interrupt-control word, the event-buffer base word, the notification address and the table offset. It can read these back together with the level register. A bit in the control word stops the level register from following its inputs. Writing a second control bit sends a one-cycle reset pulse to the downstream source logic. Stores leave through a valid/ready request channel, and each store is followed by one response that may flag an error. One store is outstanding at a time and a second request waits in a single holding slot.

Top module: `itn_notify_gen`

## Requirements
- R1: After reset, all registers, the level register and the read data are zero. `st_valid`, `src_rst` and `err_flag` are low and `ntf_ready` is high.
- R2: While the method bit is clear, level register bit (63 - n) equals `src_level[n]` one clock after the input is sampled. Bits 49:0 are zero. The level register reads at offset 0x78.
- R3: While bit 63 of the control register (offset 0x58) is set, the level register holds its value and ignores input changes.
- R4: A write to offset 0x58 stores the full value. When bit 62 of that value is set, `src_rst` is high for the one cycle after the write edge.
- R5: A read is answered on `reg_rdata` in the cycle after `reg_rd_en`. Offsets 0x58, 0x60, 0x68 and 0x70 return the stored words and 0x78 returns the level register. Any other offset returns all ones. Writes to 0x78 or to unmapped offsets change nothing.
- R6: The trigger word is bit 63 set, ORed with offset-register bits 63:32 placed in bits 31:0, ORed with the source number. The store address is the notification register (offset 0x68) with bit 0 cleared.
- R7: `st_data` carries the trigger word in big-endian byte order: byte lane k (`st_data[8k+7:8k]`) holds word bits (63-8k):(56-8k).
- R8: An accepted request is discarded, and no store is issued, when bit 0 of the notification register is 0 or the source number is 14 or more.
- R9: `st_valid` stays high with stable address and data until `st_ready`. The next store is not presented before `rsp_valid` closes the current one.
- R10: While one store is outstanding, one further request is held. `ntf_ready` is low while both places are taken, and a request then is dropped. The held request is presented in the cycle after the response.
- R11: A response with `rsp_err` high sets `err_flag`, which then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| reg_wr_en | input | 1 | register write strobe |
| reg_rd_en | input | 1 | register read strobe |
| reg_addr | input | 8 | register byte offset |
| reg_wdata | input | 64 | register write data |
| reg_rdata | output | 64 | register read data, one cycle after the strobe |
| src_level | input | 14 | interrupt source levels |
| src_rst | output | 1 | reset pulse to the source logic |
| ntf_req | input | 1 | notification request |
| ntf_src | input | 4 | source number of the request |
| ntf_ready | output | 1 | request can be taken |
| st_valid | output | 1 | store request valid |
| st_ready | input | 1 | store request taken |
| st_addr | output | 64 | store address |
| st_data | output | 64 | store data, big-endian byte lanes |
| rsp_valid | input | 1 | store response |
| rsp_err | input | 1 | response reports an error |
| err_flag | output | 1 | sticky store error |

## Verification
Every result of this block is due a fixed number of edges after its cause, and this gives the check timing. Read data, the reset pulse and a level change appear one edge after their strobe or sample. An accepted request raises `st_valid` one edge later. A response frees the outstanding place at its own edge, so a held request is visible in the next cycle. The bench drives inputs on the falling edge. It advances a behavioural model of queues and counters on each rising edge and compares all outputs at the following falling edge. Directed checks are taken at those same falling edges.

// File: rtl/itn_pkg.sv
package itn_pkg;
   localparam int DW       = 64;
   localparam int FLAG_BIT = DW - 1;
   localparam int OFF_CTRL = 'h58;
   localparam int OFF_ESB  = 'h60;
   localparam int OFF_NADR = 'h68;
   localparam int OFF_TOFF = 'h70;
   localparam int OFF_LVL  = 'h78;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_REQ  = 2'd1,
      PH_WAIT = 2'd2
   } itn_phase_e;
endpackage

// File: rtl/itn_regs.sv
module itn_regs
   import itn_pkg::*;
#(
   parameter int NSRC = 14,
   parameter int AW   = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   input  logic [NSRC-1:0] src_level,
   output logic [DW-1:0] naddr,
   output logic [DW/2-1:0] tab_off,
   output logic          src_rst
);
   localparam int HW = DW / 2;

   logic [DW-1:0] ctrl_q, esb_q, nadr_q, toff_q, lvl_q, lvl_nx, rd_mux;

   // MSB-first numbering: source n lands on bit DW-1-n
   for (genvar b = 0; b < DW; b++) begin : g_lvl
      if (DW - 1 - b < NSRC) begin : g_src
         assign lvl_nx[b] = src_level[DW-1-b];
      end else begin : g_pad
         assign lvl_nx[b] = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= '0;
      else if (!ctrl_q[DW-1]) lvl_q <= lvl_nx;
   end

   always_comb begin
      case (addr)
         AW'(OFF_CTRL): rd_mux = ctrl_q;
         AW'(OFF_ESB):  rd_mux = esb_q;
         AW'(OFF_NADR): rd_mux = nadr_q;
         AW'(OFF_TOFF): rd_mux = toff_q;
         AW'(OFF_LVL):  rd_mux = lvl_q;
         default:       rd_mux = '1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         esb_q   <= '0;
         nadr_q  <= '0;
         toff_q  <= '0;
         rdata   <= '0;
         src_rst <= 1'b0;
      end else begin
         src_rst <= 1'b0;
         if (rd_en) rdata <= rd_mux;
         if (wr_en) begin
            case (addr)
               AW'(OFF_CTRL): begin
                  ctrl_q  <= wdata;
                  src_rst <= wdata[DW-2];
               end
               AW'(OFF_ESB):  esb_q  <= wdata;
               AW'(OFF_NADR): nadr_q <= wdata;
               AW'(OFF_TOFF): toff_q <= wdata;
               default: ;
            endcase
         end
      end
   end

   assign naddr   = nadr_q;
   assign tab_off = toff_q[DW-1:HW];
endmodule

// File: rtl/itn_word.sv
module itn_word
   import itn_pkg::*;
#(
   parameter int NSRC = 14,
   parameter int SRCW = 4,
   parameter bit BIG  = 1'b1
) (
   input  logic [SRCW-1:0] src,
   input  logic [DW-1:0]   naddr,
   input  logic [DW/2-1:0] tab_off,
   output logic            ok,
   output logic [DW-1:0]   addr,
   output logic [DW-1:0]   bus
);
   localparam int NB = DW / 8;

   logic [DW-1:0] word;

   assign ok   = naddr[0] && ({1'b0, src} < (SRCW+1)'(NSRC));
   assign addr = {naddr[DW-1:1], 1'b0};
   assign word = (DW'(1) << FLAG_BIT) | DW'(tab_off) | DW'(src);

   if (BIG) begin : g_be
      for (genvar k = 0; k < NB; k++) begin : g_lane
         assign bus[8*k +: 8] = word[DW-8-8*k +: 8];
      end
   end else begin : g_le
      assign bus = word;
   end
endmodule

// File: rtl/itn_issue.sv
module itn_issue
   import itn_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_vld,
   input  logic [DW-1:0] in_addr,
   input  logic [DW-1:0] in_data,
   output logic          in_rdy,
   output logic          st_valid,
   input  logic          st_ready,
   output logic [DW-1:0] st_addr,
   output logic [DW-1:0] st_data,
   input  logic          rsp_valid,
   input  logic          rsp_err,
   output logic          err_flag
);
   itn_phase_e    ph_q;
   logic [DW-1:0] a_addr, a_data, b_addr, b_data;
   logic          b_full, push, a_done;

   assign in_rdy = !b_full;
   assign push   = in_vld && in_rdy;
   assign a_done = (ph_q == PH_WAIT) && rsp_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q     <= PH_IDLE;
         b_full   <= 1'b0;
         err_flag <= 1'b0;
         a_addr   <= '0;
         a_data   <= '0;
         b_addr   <= '0;
         b_data   <= '0;
      end else begin
         if (a_done && rsp_err) err_flag <= 1'b1;
         case (ph_q)
            PH_IDLE: if (push) begin
               ph_q   <= PH_REQ;
               a_addr <= in_addr;
               a_data <= in_data;
            end
            PH_REQ: begin
               if (st_ready) ph_q <= PH_WAIT;
               if (push) begin
                  b_full <= 1'b1;
                  b_addr <= in_addr;
                  b_data <= in_data;
               end
            end
            PH_WAIT: begin
               if (a_done) begin
                  if (b_full) begin
                     ph_q   <= PH_REQ;
                     a_addr <= b_addr;
                     a_data <= b_data;
                     b_full <= 1'b0;
                  end else if (push) begin
                     ph_q   <= PH_REQ;
                     a_addr <= in_addr;
                     a_data <= in_data;
                  end else begin
                     ph_q <= PH_IDLE;
                  end
               end else if (push) begin
                  b_full <= 1'b1;
                  b_addr <= in_addr;
                  b_data <= in_data;
               end
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign st_valid = (ph_q == PH_REQ);
   assign st_addr  = a_addr;
   assign st_data  = a_data;
endmodule

// File: rtl/itn_notify_gen.sv
module itn_notify_gen
   import itn_pkg::*;
#(
   parameter int NSRC = 14,
   parameter int SRCW = 4,
   parameter int AW   = 8,
   parameter bit BIG  = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_wr_en,
   input  logic            reg_rd_en,
   input  logic [AW-1:0]   reg_addr,
   input  logic [63:0]     reg_wdata,
   output logic [63:0]     reg_rdata,
   input  logic [NSRC-1:0] src_level,
   output logic            src_rst,
   input  logic            ntf_req,
   input  logic [SRCW-1:0] ntf_src,
   output logic            ntf_ready,
   output logic            st_valid,
   input  logic            st_ready,
   output logic [63:0]     st_addr,
   output logic [63:0]     st_data,
   input  logic            rsp_valid,
   input  logic            rsp_err,
   output logic            err_flag
);
   if (NSRC < 1 || NSRC > DW / 2) begin : g_bad_nsrc
      $error("itn_notify_gen: NSRC out of range");
   end
   if ((1 << SRCW) < NSRC) begin : g_bad_srcw
      $error("itn_notify_gen: SRCW too narrow for NSRC");
   end
   if (AW < 7) begin : g_bad_aw
      $error("itn_notify_gen: AW cannot hold the register offsets");
   end

   logic [DW-1:0]   naddr, w_addr, w_bus;
   logic [DW/2-1:0] tab_off;
   logic            w_ok;

   itn_regs #(.NSRC(NSRC), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr_en), .rd_en(reg_rd_en), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata),
      .src_level(src_level),
      .naddr(naddr), .tab_off(tab_off), .src_rst(src_rst)
   );

   itn_word #(.NSRC(NSRC), .SRCW(SRCW), .BIG(BIG)) u_word (
      .src(ntf_src), .naddr(naddr), .tab_off(tab_off),
      .ok(w_ok), .addr(w_addr), .bus(w_bus)
   );

   itn_issue u_issue (
      .clk(clk), .rst_n(rst_n),
      .in_vld(ntf_req && w_ok), .in_addr(w_addr), .in_data(w_bus),
      .in_rdy(ntf_ready),
      .st_valid(st_valid), .st_ready(st_ready),
      .st_addr(st_addr), .st_data(st_data),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err),
      .err_flag(err_flag)
   );
endmodule

// File: rtl/itn_notify_gen_chk.sv
module itn_notify_gen_chk #(
   parameter int NSRC = 14,
   parameter int SRCW = 4,
   parameter int AW   = 8,
   parameter bit BIG  = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            reg_wr_en,
   input logic            reg_rd_en,
   input logic [AW-1:0]   reg_addr,
   input logic [63:0]     reg_wdata,
   input logic [63:0]     reg_rdata,
   input logic [NSRC-1:0] src_level,
   input logic            src_rst,
   input logic            ntf_req,
   input logic [SRCW-1:0] ntf_src,
   input logic            ntf_ready,
   input logic            st_valid,
   input logic            st_ready,
   input logic [63:0]     st_addr,
   input logic [63:0]     st_data,
   input logic            rsp_valid,
   input logic            rsp_err,
   input logic            err_flag
);
   // R9
   st_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid && !st_ready |=> st_valid && $stable(st_addr) && $stable(st_data));

   // R6
   st_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid |-> (BIG ? st_data[7] : st_data[63]) && !st_addr[0]);

   // R4
   src_rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      src_rst |-> $past(reg_wr_en && reg_addr == AW'('h58) && reg_wdata[62]));

   // R11
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag);

   // R11
   err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_flag) |-> $past(rsp_valid && rsp_err));
endmodule

bind itn_notify_gen itn_notify_gen_chk #(.NSRC(NSRC), .SRCW(SRCW), .AW(AW), .BIG(BIG)) u_chk (.*);

// File: tb/sim_itn_notify_gen.sv
module sim_itn_notify_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic [13:0] src_level = '0;
   logic        src_rst;
   logic        ntf_req = 1'b0;
   logic [3:0]  ntf_src = '0;
   logic        ntf_ready, st_valid;
   logic        st_ready = 1'b1;
   logic [63:0] st_addr, st_data;
   logic        rsp_valid = 1'b0, rsp_err = 1'b0;
   logic        err_flag;

   always #5 clk = ~clk;

   itn_notify_gen u0 (.*);

   int ncmp = 0, nbad = 0, cyc = 0;
   bit done = 1'b0;

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      ncmp++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s: got %h, want %h", tag, act, exp);
      end
   endtask

   // behavioural reference
   typedef struct { logic [63:0] a; logic [63:0] d; } ent_t;
   ent_t        q[$];
   logic [63:0] m_ctrl, m_esb, m_nadr, m_toff, m_lvl, m_rdata;
   bit          m_srst, m_err;
   int          m_ph, wcnt, lat_cfg = 0;
   bit          rdy_slow = 1'b0, err_inj = 1'b0;

   always @(posedge clk) begin
      logic [63:0] w;
      bit rdy;
      cyc++;
      if (!rst_n) begin
         m_ctrl = '0; m_esb = '0; m_nadr = '0; m_toff = '0; m_lvl = '0;
         m_rdata = '0; m_srst = 0; m_err = 0; m_ph = 0; wcnt = 0;
         q.delete();
      end else begin
         rdy = (q.size() < 2);
         if (reg_rd_en) begin
            case (reg_addr)
               8'h58: m_rdata = m_ctrl;
               8'h60: m_rdata = m_esb;
               8'h68: m_rdata = m_nadr;
               8'h70: m_rdata = m_toff;
               8'h78: m_rdata = m_lvl;
               default: m_rdata = '1;
            endcase
         end
         if (!m_ctrl[63]) begin
            m_lvl = '0;
            for (int n = 0; n < 14; n++) m_lvl[63-n] = src_level[n];
         end
         if (m_ph == 2 && rsp_valid) begin
            if (rsp_err) m_err = 1;
            void'(q.pop_front());
            m_ph = 0;
         end else if (m_ph == 2 && wcnt > 0) wcnt--;
         else if (m_ph == 1 && st_ready) begin m_ph = 2; wcnt = lat_cfg; end
         if (ntf_req && rdy && m_nadr[0] && ntf_src < 14) begin
            w = 64'h8000_0000_0000_0000 | {32'h0, m_toff[63:32]} | 64'(ntf_src);
            q.push_back('{a: {m_nadr[63:1], 1'b0}, d: {<<8{w}}});
         end
         if (m_ph == 0 && q.size() > 0) m_ph = 1;
         m_srst = 0;
         if (reg_wr_en) begin
            case (reg_addr)
               8'h58: begin m_ctrl = reg_wdata; m_srst = reg_wdata[62]; end
               8'h60: m_esb = reg_wdata;
               8'h68: m_nadr = reg_wdata;
               8'h70: m_toff = reg_wdata;
               default: ;
            endcase
         end
      end
   end

   // responder and ready pattern
   always @(negedge clk) begin
      rsp_valid <= (m_ph == 2 && wcnt == 0);
      rsp_err   <= err_inj;
      st_ready  <= rdy_slow ? cyc[1] : 1'b1;
   end

   // per-cycle comparison
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R9 st_valid", 64'(st_valid), 64'(m_ph == 1 && q.size() > 0));
         if (m_ph == 1 && q.size() > 0) begin
            chk("R6 st_addr", st_addr, q[0].a);
            chk("R7 st_data", st_data, q[0].d);
         end
         chk("R10 ntf_ready", 64'(ntf_ready), 64'(q.size() < 2));
         chk("R11 err_flag", 64'(err_flag), 64'(m_err));
         chk("R4 src_rst", 64'(src_rst), 64'(m_srst));
         chk("R5 reg_rdata", reg_rdata, m_rdata);
      end
   end

   task automatic wr(input logic [7:0] a, input logic [63:0] d);
      reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a);
      reg_rd_en = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd_en = 1'b0;
   endtask

   task automatic ntf(input logic [3:0] s);
      ntf_req = 1'b1; ntf_src = s;
      @(negedge clk);
      ntf_req = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 st_valid", 64'(st_valid), 64'd0);
      chk("R1 ntf_ready", 64'(ntf_ready), 64'd1);
      chk("R1 err_flag", 64'(err_flag), 64'd0);
      rd(8'h68);
      chk("R1 naddr", reg_rdata, 64'd0);
      rd(8'h78);
      chk("R1 level", reg_rdata, 64'd0);

      // R2 level tracking
      src_level = 14'h0001;
      @(negedge clk);
      rd(8'h78);
      chk("R2 src0", reg_rdata, 64'h8000_0000_0000_0000);
      src_level = 14'h2000;
      @(negedge clk);
      rd(8'h78);
      chk("R2 src13", reg_rdata, 64'h0004_0000_0000_0000);

      // R3 method bit freezes the level register
      wr(8'h58, 64'h8000_0000_0000_0000);
      src_level = 14'h0003;
      repeat (2) @(negedge clk);
      rd(8'h78);
      chk("R3 frozen", reg_rdata, 64'h0004_0000_0000_0000);
      wr(8'h58, 64'h0);
      @(negedge clk);
      rd(8'h78);
      chk("R3 released", reg_rdata, 64'hC000_0000_0000_0000);

      // R4 reset pulse and stored value
      wr(8'h58, 64'h4000_0000_0000_0000);
      chk("R4 pulse", 64'(src_rst), 64'd1);
      @(negedge clk);
      chk("R4 pulse ends", 64'(src_rst), 64'd0);
      rd(8'h58);
      chk("R4 stored", reg_rdata, 64'h4000_0000_0000_0000);

      // R5 readback, unmapped reads, ignored writes
      wr(8'h60, 64'h0000_00F0_0000_0001);
      rd(8'h60);
      chk("R5 esb", reg_rdata, 64'h0000_00F0_0000_0001);
      rd(8'h48);
      chk("R5 unmapped", reg_rdata, 64'hFFFF_FFFF_FFFF_FFFF);
      wr(8'h78, 64'h1234);
      wr(8'h50, 64'h1234);
      rd(8'h78);
      chk("R5 level ro", reg_rdata, 64'hC000_0000_0000_0000);

      // R8 no store without valid address
      wr(8'h70, 64'h0000_0ABC_FFFF_FFFF);
      wr(8'h68, 64'h0000_1234_5678_9000);
      ntf(4'd5);
      chk("R8 invalid addr", 64'(st_valid), 64'd0);
      wr(8'h68, 64'h0000_1234_5678_9001);
      ntf(4'd14);
      chk("R8 src range", 64'(st_valid), 64'd0);

      // R6 / R7 trigger word and byte order
      lat_cfg = 2;
      ntf(4'd5);
      chk("R6 addr", st_addr, 64'h0000_1234_5678_9000);
      chk("R7 data", st_data, 64'hBD0A_0000_0000_0080);
      repeat (8) @(negedge clk);

      // R10 one-deep holding slot
      rdy_slow = 1'b1; lat_cfg = 4;
      ntf_req = 1'b1; ntf_src = 4'd1;
      @(negedge clk);
      ntf_src = 4'd2;
      @(negedge clk);
      ntf_src = 4'd3;
      chk("R10 full", 64'(ntf_ready), 64'd0);
      @(negedge clk);
      ntf_req = 1'b0;
      repeat (30) @(negedge clk);
      chk("R10 drained", 64'(ntf_ready), 64'd1);
      rdy_slow = 1'b0;

      // R11 sticky error
      err_inj = 1'b1; lat_cfg = 0;
      ntf(4'd7);
      repeat (5) @(negedge clk);
      chk("R11 set", 64'(err_flag), 64'd1);
      err_inj = 1'b0;
      ntf(4'd8);
      repeat (5) @(negedge clk);
      chk("R11 sticky", 64'(err_flag), 64'd1);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         ncmp++; nbad++;
         $display("FAIL watchdog: got timeout, want completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
         $finish;
      end
   end
endmodule